// File: doc/BRIEF.md
# PWM-Synchronised ADC Trigger Generator

This block produces start-of-conversion pulses for an ADC, timed against the local time-base counter of one PWM generator. It watches the counter value and compares it with two programmable compare points, a primary and a secondary. The counter may run upward or downward, and a match fires in either direction. A trigger fires only on the cycle in which the counter moves onto a compare value. A counter that stays on that value does not fire again.

The primary path has a postscaler, so only every Nth primary event becomes a trigger. A start delay holds back all compare triggers until a programmed number of PWM period boundaries have passed after the generator is enabled. A mode input selects how the two compare paths reach the outputs. In split mode they appear on separate outputs. In merge mode the secondary events are ORed onto the primary output.

A third output turns each rising edge of a current-limit input into a trigger. That path works whether or not the generator is enabled and is unaffected by the start delay. All inputs are taken to be synchronous to `clk`.

Top module: `pwm_adc_trig_gen`

## Requirements
- R1: When the counter takes a value equal to `pri_cmp` and that value differs from the counter value at the previous clock edge, `trig_pri` is high for exactly one cycle, registered one clock later. This holds for upward and downward counting (split mode, divide select 0, start delay satisfied).
- R2: A counter held at a compare value produces no further trigger until it leaves that value and returns.
- R3: A counter change onto `sec_cmp` produces a one-cycle pulse on `trig_sec` in split mode (`dual_mode` = 0), one clock later.
- R4: With `div_sel` = n, only every (n+1)th armed primary event produces a trigger. The first trigger after enable comes on the (n+1)th event, so n = 15 gives one trigger per 16 events.
- R5: The divider does not act on secondary events. Every armed secondary match produces a trigger at any `div_sel` setting.
- R6: With `start_dly` = s, compare triggers are suppressed until s `period_strobe` pulses have been seen while enabled. The strobe that completes the count arms the generator for the rest of that period, and s = 0 means the generator is armed at once.
- R7: While `enable` is 0, no compare trigger is produced and both the start-delay count and the divider count are cleared. A re-enable therefore repeats the full start delay and restarts the divide sequence.
- R8: With `dual_mode` = 1, secondary events are ORed onto `trig_pri` and `trig_sec` stays 0. With `dual_mode` = 0 the two paths use separate outputs.
- R9: Each rising edge of `ilim_in` gives exactly one `trig_ilim` pulse one clock later, regardless of `enable` and of the start delay. A held-high input does not fire again.
- R10: During and right after reset all three trigger outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Generator enable; low clears start-delay and divider state |
| cnt | input | CNT_W | Local PWM time-base counter value |
| period_strobe | input | 1 | One-cycle pulse at each PWM period boundary |
| pri_cmp | input | CNT_W | Primary compare value |
| sec_cmp | input | CNT_W | Secondary compare value |
| div_sel | input | DIV_W | Primary divide select, ratio div_sel+1 |
| start_dly | input | START_W | Period boundaries to wait after enable |
| dual_mode | input | 1 | 1 merges secondary onto trig_pri, 0 keeps them apart |
| ilim_in | input | 1 | Current-limit signal |
| trig_pri | output | 1 | Primary (or merged) trigger pulse |
| trig_sec | output | 1 | Secondary trigger pulse (split mode) |
| trig_ilim | output | 1 | Current-limit trigger pulse |

## Verification
The bench checks equality in both counting directions and holds the counter on a compare value. A design that fired on a level would emit a pulse train instead of a single pulse. It runs whole PWM periods at divide ratios of 3 and 16 and checks which period carries the trigger, since an off-by-one in the postscaler moves the trigger one period early or late. It also checks that the secondary path keeps firing at every divide setting. Start delay is checked period by period, both from enable and after a disable and re-enable, which exposes an arming counter that is not cleared or that arms one boundary off. Merge mode must double the pulses on the primary output while the secondary output stays silent. The current-limit input must fire once per edge even when the generator is disabled.

// File: rtl/adc_trig_pkg.sv
// Shared types for the PWM ADC trigger generator.
// Assumes: nothing beyond IEEE 1800-2017.
package adc_trig_pkg;

    // How the secondary compare path reaches the outputs.
    typedef enum logic {
        TRIG_SPLIT = 1'b0,
        TRIG_MERGE = 1'b1
    } trig_route_e;

    // Number of compare channels: index 0 primary, index 1 secondary.
    localparam int unsigned N_CMP   = 2;
    localparam int unsigned CH_PRI  = 0;
    localparam int unsigned CH_SEC  = 1;

    // Registered trigger bundle driven to the ports.
    typedef struct packed {
        logic pri;
        logic sec;
        logic ilim;
    } trig_bundle_t;

endpackage

// File: rtl/adc_trig_cmp.sv
// Change-qualified equality detector.
// Flags a hit when the counter equals the compare value and differs from
// its value at the previous edge, so a parked counter does not re-fire.
// Assumes: cnt_prev is the counter registered one clock earlier.
module adc_trig_cmp #(
    parameter int unsigned CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cnt_prev,
    input  logic [CNT_W-1:0] cmp_val,
    output logic             hit
);

    // Match only on the cycle the counter moves onto the compare value.
    always_comb begin
        hit = (cnt == cmp_val) && (cnt != cnt_prev);
    end

endmodule

// File: rtl/adc_trig_start.sv
// Start-delay gate: counts period boundaries after enable and reports
// armed once the programmed number has passed.
// Assumes: period_strobe is a one-cycle pulse; start_dly is quasi-static.
module adc_trig_start #(
    parameter int unsigned START_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               period_strobe,
    input  logic [START_W-1:0] start_dly,
    output logic               armed
);

    logic [START_W-1:0] seen_q;

    // Armed once the boundaries counted reach the programmed delay.
    always_comb begin
        armed = (seen_q >= start_dly);
    end

    // Count boundaries while enabled and not yet armed; clear on disable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (!enable) begin
            seen_q <= '0;
        end else if (period_strobe && !armed) begin
            seen_q <= seen_q + 1'b1;
        end
    end

endmodule

// File: rtl/adc_trig_postscale.sv
// Event postscaler: passes one event out of every ratio_sel+1.
// Assumes: evt_in is a one-cycle pulse; cleared whenever enable is low.
// A compare with >= keeps the sequence alive if ratio_sel is lowered.
module adc_trig_postscale #(
    parameter int unsigned DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             evt_in,
    input  logic [DIV_W-1:0] ratio_sel,
    output logic             evt_out
);

    logic [DIV_W-1:0] tally_q;
    logic             last_of_group;

    // The event that completes a group is the one passed on.
    always_comb begin
        last_of_group = (tally_q >= ratio_sel);
        evt_out       = evt_in && last_of_group;
    end

    // Advance the tally per event, wrap at the end of a group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tally_q <= '0;
        end else if (!enable) begin
            tally_q <= '0;
        end else if (evt_in) begin
            tally_q <= last_of_group ? '0 : tally_q + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_adc_trig_gen.sv
// PWM-synchronised ADC trigger generator (top).
// Compares the PWM time-base counter with a primary and a secondary
// value, applies a start delay and a primary postscaler, routes the
// secondary path split or merged, and adds a current-limit edge trigger.
// Assumes: all inputs synchronous to clk; outputs are registered pulses.
module pwm_adc_trig_gen
    import adc_trig_pkg::*;
#(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned DIV_W   = 4,
    parameter int unsigned START_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [CNT_W-1:0]   cnt,
    input  logic               period_strobe,
    input  logic [CNT_W-1:0]   pri_cmp,
    input  logic [CNT_W-1:0]   sec_cmp,
    input  logic [DIV_W-1:0]   div_sel,
    input  logic [START_W-1:0] start_dly,
    input  logic               dual_mode,
    input  logic               ilim_in,
    output logic               trig_pri,
    output logic               trig_sec,
    output logic               trig_ilim
);

    logic [CNT_W-1:0] cnt_prev_q;
    logic [CNT_W-1:0] cmp_vals [N_CMP];
    logic [N_CMP-1:0] cmp_hit;
    logic             armed;
    logic             pri_evt;
    logic             sec_evt;
    logic             pri_pass;
    logic             ilim_q;
    logic             ilim_rise;
    trig_route_e      route;
    trig_bundle_t     next_trig;
    trig_bundle_t     trig_q;

    // Collect compare values into a channel-indexed array.
    always_comb begin
        cmp_vals[CH_PRI] = pri_cmp;
        cmp_vals[CH_SEC] = sec_cmp;
    end

    // One change-qualified comparator per compare channel.
    for (genvar ch = 0; ch < N_CMP; ch++) begin : g_cmp
        adc_trig_cmp #(.CNT_W(CNT_W)) u_cmp (
            .cnt      (cnt),
            .cnt_prev (cnt_prev_q),
            .cmp_val  (cmp_vals[ch]),
            .hit      (cmp_hit[ch])
        );
    end

    adc_trig_start #(.START_W(START_W)) u_start (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .period_strobe (period_strobe),
        .start_dly     (start_dly),
        .armed         (armed)
    );

    adc_trig_postscale #(.DIV_W(DIV_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .evt_in    (pri_evt),
        .ratio_sel (div_sel),
        .evt_out   (pri_pass)
    );

    // Gate compare hits with enable and arming; detect current-limit edge.
    always_comb begin
        route     = trig_route_e'(dual_mode);
        pri_evt   = enable && armed && cmp_hit[CH_PRI];
        sec_evt   = enable && armed && cmp_hit[CH_SEC];
        ilim_rise = ilim_in && !ilim_q;
        next_trig.pri  = pri_pass || ((route == TRIG_MERGE) && sec_evt);
        next_trig.sec  = (route == TRIG_SPLIT) && sec_evt;
        next_trig.ilim = ilim_rise;
    end

    // Track the previous counter value and the current-limit level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_prev_q <= '0;
            ilim_q     <= 1'b0;
        end else begin
            cnt_prev_q <= cnt;
            ilim_q     <= ilim_in;
        end
    end

    // Register the trigger pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= '0;
        end else begin
            trig_q <= next_trig;
        end
    end

    assign trig_pri  = trig_q.pri;
    assign trig_sec  = trig_q.sec;
    assign trig_ilim = trig_q.ilim;

endmodule

// File: rtl/adc_trig_gen_chk.sv
// Port-level checker for pwm_adc_trig_gen, attached by bind below.
// Assumes: same parameters as the top; observes ports only.
module adc_trig_gen_chk #(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned DIV_W   = 4,
    parameter int unsigned START_W = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               enable,
    input logic [CNT_W-1:0]   cnt,
    input logic               period_strobe,
    input logic [CNT_W-1:0]   pri_cmp,
    input logic [CNT_W-1:0]   sec_cmp,
    input logic [DIV_W-1:0]   div_sel,
    input logic [START_W-1:0] start_dly,
    input logic               dual_mode,
    input logic               ilim_in,
    input logic               trig_pri,
    input logic               trig_sec,
    input logic               trig_ilim
);

    // R1: a primary-output pulse follows a counter match one clock earlier.
    p_pri_after_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pri |-> (($past(cnt) == $past(pri_cmp)) ||
                      ($past(dual_mode) && ($past(cnt) == $past(sec_cmp)))));

    // R3: a secondary pulse follows a secondary match one clock earlier.
    p_sec_after_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trig_sec |-> ($past(cnt) == $past(sec_cmp)));

    // R7: no compare trigger when the generator was disabled.
    p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> (!trig_pri && !trig_sec));

    // R8: merge mode keeps the secondary output silent.
    p_merge_sec_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dual_mode) |-> !trig_sec);

    // R9: current-limit trigger is a single-cycle pulse.
    p_ilim_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trig_ilim |=> !trig_ilim);

    // R9: current-limit trigger needs the input high one clock earlier.
    p_ilim_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trig_ilim |-> $past(ilim_in));

endmodule

bind pwm_adc_trig_gen adc_trig_gen_chk #(
    .CNT_W(CNT_W), .DIV_W(DIV_W), .START_W(START_W)
) u_chk (.*);

// File: tb/pwm_adc_trig_gen_test.sv
`timescale 1ns/1ps
// Directed bench for pwm_adc_trig_gen; one task per scenario.
module pwm_adc_trig_gen_test;

    localparam int CNT_W   = 16;
    localparam int DIV_W   = 4;
    localparam int START_W = 6;
    localparam int PER     = 16;
    localparam int PRI_AT  = 5;
    localparam int SEC_AT  = 11;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               enable = 1'b0;
    logic [CNT_W-1:0]   cnt = '0;
    logic               period_strobe = 1'b0;
    logic [CNT_W-1:0]   pri_cmp = CNT_W'(PRI_AT);
    logic [CNT_W-1:0]   sec_cmp = CNT_W'(SEC_AT);
    logic [DIV_W-1:0]   div_sel = '0;
    logic [START_W-1:0] start_dly = '0;
    logic               dual_mode = 1'b0;
    logic               ilim_in = 1'b0;
    logic               trig_pri;
    logic               trig_sec;
    logic               trig_ilim;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pwm_adc_trig_gen #(.CNT_W(CNT_W), .DIV_W(DIV_W), .START_W(START_W)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cnt(cnt),
        .period_strobe(period_strobe), .pri_cmp(pri_cmp), .sec_cmp(sec_cmp),
        .div_sel(div_sel), .start_dly(start_dly), .dual_mode(dual_mode),
        .ilim_in(ilim_in), .trig_pri(trig_pri), .trig_sec(trig_sec),
        .trig_ilim(trig_ilim)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Sweep one PWM period upward and count pulses on each output.
    task automatic run_period(output int np, output int ns);
        np = 0;
        ns = 0;
        for (int i = 0; i < PER; i++) begin
            cnt = CNT_W'(i);
            period_strobe = (i == 0);
            tick();
            np += int'(trig_pri);
            ns += int'(trig_sec);
        end
        period_strobe = 1'b0;
    endtask

    task automatic restart();
        enable = 1'b0;
        tick();
        enable = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        chk("R10 reset trig_pri", int'(trig_pri), 0);
        chk("R10 reset trig_sec", int'(trig_sec), 0);
        chk("R10 reset trig_ilim", int'(trig_ilim), 0);
        rst_n = 1'b1;
        tick();
        chk("R10 post-reset trig_pri", int'(trig_pri), 0);
    endtask

    task automatic t_up_down();
        int ups = 0;
        int downs = 0;
        div_sel = 0; start_dly = 0; dual_mode = 0;
        restart();
        for (int i = 0; i <= 12; i++) begin
            cnt = CNT_W'(i);
            tick();
            chk($sformatf("R1 up cnt=%0d", i), int'(trig_pri), int'(i == PRI_AT));
            ups += int'(trig_pri);
        end
        for (int i = 12; i >= 0; i--) begin
            cnt = CNT_W'(i);
            tick();
            chk($sformatf("R1 down cnt=%0d", i), int'(trig_pri), int'(i == PRI_AT));
            downs += int'(trig_pri);
        end
        chk("R1 up pulses", ups, 1);
        chk("R1 down pulses", downs, 1);
    endtask

    task automatic t_hold();
        int extra = 0;
        cnt = CNT_W'(PRI_AT - 1);
        tick();
        cnt = CNT_W'(PRI_AT);
        tick();
        chk("R2 first arrival", int'(trig_pri), 1);
        for (int k = 0; k < 5; k++) begin
            tick();
            extra += int'(trig_pri);
        end
        chk("R2 held no refire", extra, 0);
        cnt = CNT_W'(PRI_AT + 1);
        tick();
        cnt = CNT_W'(PRI_AT);
        tick();
        chk("R2 return refires", int'(trig_pri), 1);
    endtask

    task automatic t_divider();
        int np;
        int ns;
        div_sel = 2; start_dly = 0; dual_mode = 0;
        restart();
        for (int p = 1; p <= 6; p++) begin
            run_period(np, ns);
            chk($sformatf("R4 div3 period %0d", p), np, int'(p % 3 == 0));
            chk($sformatf("R5 sec undivided period %0d", p), ns, 1);
        end
        div_sel = 15;
        restart();
        for (int p = 1; p <= 16; p++) begin
            run_period(np, ns);
            chk($sformatf("R4 div16 period %0d", p), np, int'(p == 16));
        end
        div_sel = 0;
    endtask

    task automatic t_start_delay();
        int np;
        int ns;
        div_sel = 0; start_dly = 3; dual_mode = 0;
        restart();
        for (int p = 1; p <= 4; p++) begin
            run_period(np, ns);
            chk($sformatf("R6 start3 pri period %0d", p), np, int'(p >= 3));
            chk($sformatf("R6 start3 sec period %0d", p), ns, int'(p >= 3));
        end
        enable = 1'b0;
        run_period(np, ns);
        chk("R7 disabled pri", np, 0);
        chk("R7 disabled sec", ns, 0);
        enable = 1'b1;
        for (int p = 1; p <= 3; p++) begin
            run_period(np, ns);
            chk($sformatf("R7 re-enable delay period %0d", p), np, int'(p == 3));
        end
        start_dly = 0;
    endtask

    task automatic t_div_clear();
        int np;
        int ns;
        div_sel = 2; start_dly = 0; dual_mode = 0;
        restart();
        for (int p = 1; p <= 2; p++) begin
            run_period(np, ns);
            chk($sformatf("R7 pre-clear period %0d", p), np, 0);
        end
        restart();
        for (int p = 1; p <= 3; p++) begin
            run_period(np, ns);
            chk($sformatf("R7 divider restarted period %0d", p), np, int'(p == 3));
        end
        div_sel = 0;
    endtask

    task automatic t_merge();
        int np;
        int ns;
        div_sel = 0; start_dly = 0; dual_mode = 1;
        restart();
        run_period(np, ns);
        chk("R8 merge pri pulses", np, 2);
        chk("R8 merge sec silent", ns, 0);
        div_sel = 1;
        restart();
        run_period(np, ns);
        chk("R8 merge div2 period 1", np, 1);
        run_period(np, ns);
        chk("R8 merge div2 period 2", np, 2);
        dual_mode = 0; div_sel = 0;
        restart();
        run_period(np, ns);
        chk("R8 split pri", np, 1);
        chk("R8 split sec", ns, 1);
    endtask

    task automatic t_ilim();
        int extra = 0;
        enable = 1'b0;
        ilim_in = 1'b1;
        tick();
        chk("R9 ilim while disabled", int'(trig_ilim), 1);
        for (int k = 0; k < 3; k++) begin
            tick();
            extra += int'(trig_ilim);
        end
        ilim_in = 1'b0;
        tick();
        extra += int'(trig_ilim);
        chk("R9 ilim held no refire", extra, 0);
        start_dly = 5;
        enable = 1'b1;
        tick();
        ilim_in = 1'b1;
        tick();
        chk("R9 ilim during start delay", int'(trig_ilim), 1);
        ilim_in = 1'b0;
        start_dly = 0;
        tick();
    endtask

    initial begin
        t_reset();
        t_up_down();
        t_hold();
        t_divider();
        t_start_delay();
        t_div_clear();
        t_merge();
        t_ilim();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule